// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA

This block feeds a MAC transmit FIFO from a chain of descriptors held in memory. Each descriptor names a buffer, a byte count with a few flag bits, and the address of the next descriptor. The engine reads each descriptor and streams the buffer's bytes one per handshake. It then marks the descriptor finished by writing its control word back with a done flag. After that it follows the chain to the next descriptor.

The engine stops after finishing a descriptor flagged as the last one in the ring. It also stops, without sending anything, on a descriptor that software has not handed to hardware. Software restarts it by loading a new next pointer and setting the active bit.

MAC status events are collected in a sticky status register. A fatal event stops the engine at once. An interrupt line rises when a descriptor that asks for it is finished, and stays high until the host acknowledges it.

Top module: `txdesc_dma`

## Requirements
- R1: A descriptor at byte address P is three 32-bit words: buffer address at P, control word at P+4, next pointer at P+8. They are fetched in that order, with at most one memory read outstanding. Control word bits: 31 = last in ring, 30 = end of packet, 29 = interrupt on finish, 24 = hardware owned. Bits 12:0 are the byte count.
- R2: Buffer bytes leave in address order. Buffer words are little-endian, so byte 0 is bits 7:0. Exactly the count of bytes is sent. `fifo_data` holds steady while `fifo_valid` is high and `fifo_ready` is low. `fifo_last` is high on the final byte of a descriptor whose end-of-packet bit is set.
- R3: After a descriptor's last byte, the control word is written back to P+4 with bit 15 (done) set. This happens once, with no byte pending, and before any read of the next descriptor.
- R4: After finishing a descriptor with bit 31 set, the engine clears the active bit (status bit 9) and issues no further memory reads.
- R5: A descriptor whose bit 24 is clear stops the engine. No byte is sent and its control word is not written.
- R6: Register map by `reg_addr`: 0 = current pointer (read only), 1 = next pointer, 2 = status, 3 = interrupt. Writing status with bit 9 set while idle starts the engine at the next pointer. Writes to the next pointer while active are ignored.
- R7: `irq` rises after the write-back of a descriptor with bit 29 set. It stays high until a write to register 3 with bit 0 set. It does not rise for descriptors without bit 29.
- R8: A MAC event ORs `mac_flags` {ok, max-try, collision, underflow} into status bits 3..0. These bits are sticky and are cleared by a start.
- R9: A MAC event carrying max-try (flag bit 2) or underflow (flag bit 0) stops the engine on that clock edge. The byte stream is dropped, active clears, and no done is written.
- R10: Status bit 7 is set by a read strobe of register 2. It is cleared by the next MAC event or start.
- R11: A descriptor with byte count zero sends no byte but is still written back with done.
- R12: After reset, status, interrupt, both pointers and `fifo_valid` are zero.
- R13: The current pointer shows the descriptor being worked on. The next pointer takes the next field of each fetched descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 2 | Host register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| mem_wr_en | output | 1 | Descriptor write-back strobe |
| mem_wr_addr | output | AW | Write-back byte address |
| mem_wr_data | output | 32 | Write-back data |
| fifo_valid | output | 1 | Byte valid toward the MAC FIFO |
| fifo_data | output | 8 | Byte value |
| fifo_last | output | 1 | Final byte of a packet |
| fifo_ready | input | 1 | FIFO accepts the byte |
| mac_evt | input | 1 | MAC status event strobe |
| mac_flags | input | 4 | Event flags {ok, max-try, collision, underflow} |

## Verification
Suppose the walker holds a wrong pointer or a wrong remaining count. That shows up within a handful of cycles as a byte mismatch or a missing or extra byte at the FIFO. It also shows as a control word in memory without, or wrongly with, its done bit. Suppose the halt decision is wrong. The active bit then stays set, or a fetch continues past a ring end or an unowned descriptor, and the status and pointer registers read back the wrong values once the engine should be idle. Interrupt and sticky-status faults are visible at the next host read.

// File: rtl/txdesc_pkg.sv
`timescale 1ns/1ps
package txdesc_pkg;
   // control word flag positions (decoded by software too)
   localparam int CB_RING_END = 31;
   localparam int CB_PKT_END  = 30;
   localparam int CB_IRQ      = 29;
   localparam int CB_HW_OWN   = 24;
   localparam int CB_DONE     = 15;

   // status register bit positions
   localparam int SB_ACTIVE = 9;
   localparam int SB_READ   = 7;

   // host register indices
   localparam logic [1:0] RI_CUR  = 2'd0;
   localparam logic [1:0] RI_NEXT = 2'd1;
   localparam logic [1:0] RI_STAT = 2'd2;
   localparam logic [1:0] RI_IRQ  = 2'd3;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_GET_BUF,
      WK_GET_CTL,
      WK_GET_NXT,
      WK_GET_DATA,
      WK_EMIT,
      WK_DONE
   } wk_state_t;
endpackage

// File: rtl/txdesc_regs.sv
`timescale 1ns/1ps
module txdesc_regs
   import txdesc_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic [AW-1:0] cur_ptr,
   input  logic [AW-1:0] nxt_ptr,
   input  logic          active,
   input  logic          irq_set,
   input  logic          mac_evt,
   input  logic [3:0]    mac_flags,
   output logic          start,
   output logic          nxt_wr,
   output logic          abort,
   output logic          irq
);
   logic [3:0] sticky_q;
   logic       rd_flag_q;
   logic       irq_q;
   logic       irq_ack;

   assign start   = reg_wr && (reg_addr == RI_STAT) && reg_wdata[SB_ACTIVE] && !active;
   assign nxt_wr  = reg_wr && (reg_addr == RI_NEXT) && !active;
   assign irq_ack = reg_wr && (reg_addr == RI_IRQ) && reg_wdata[0];
   assign abort   = mac_evt && (mac_flags[2] || mac_flags[0]);
   assign irq     = irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sticky_q  <= '0;
         rd_flag_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         if (start) begin
            sticky_q  <= '0;
            rd_flag_q <= 1'b0;
         end else if (mac_evt) begin
            sticky_q  <= sticky_q | mac_flags;
            rd_flag_q <= 1'b0;
         end else if (reg_rd && (reg_addr == RI_STAT)) begin
            rd_flag_q <= 1'b1;
         end
         if (irq_set)
            irq_q <= 1'b1;
         else if (irq_ack)
            irq_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_addr)
         RI_CUR:  reg_rdata = 32'(cur_ptr);
         RI_NEXT: reg_rdata = 32'(nxt_ptr);
         RI_STAT: reg_rdata = {22'b0, active, 1'b0, rd_flag_q, 3'b0, sticky_q};
         default: reg_rdata = {31'b0, irq_q};
      endcase
   end
endmodule

// File: rtl/txdesc_unpack.sv
`timescale 1ns/1ps
module txdesc_unpack #(
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        ld,
   input  logic [31:0] ld_word,
   input  logic [2:0]  ld_nbytes,
   input  logic        ld_eop,
   output logic        busy,
   output logic        out_valid,
   output logic [7:0]  out_data,
   output logic        out_last,
   input  logic        out_ready
);
   logic [31:0] sh_q;
   logic [31:0] sh_next;
   logic [2:0]  cnt_q;
   logic        eop_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_data = sh_q[31:24];
         assign sh_next  = {sh_q[23:0], 8'h00};
      end else begin : g_lsb
         assign out_data = sh_q[7:0];
         assign sh_next  = {8'h00, sh_q[31:8]};
      end
   endgenerate

   assign out_valid = (cnt_q != 3'd0);
   assign busy      = out_valid;
   assign out_last  = eop_q && (cnt_q == 3'd1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sh_q  <= '0;
         cnt_q <= '0;
         eop_q <= 1'b0;
      end else if (ld) begin
         sh_q  <= ld_word;
         cnt_q <= ld_nbytes;
         eop_q <= ld_eop;
      end else if (out_valid && out_ready) begin
         sh_q  <= sh_next;
         cnt_q <= cnt_q - 3'd1;
      end
   end
endmodule

// File: rtl/txdesc_walker.sv
`timescale 1ns/1ps
module txdesc_walker
   import txdesc_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   input  logic          nxt_wr,
   input  logic [AW-1:0] nxt_wdata,
   output logic          mem_rd_req,
   output logic [AW-1:0] mem_rd_addr,
   input  logic          mem_rd_valid,
   input  logic [31:0]   mem_rd_data,
   output logic          mem_wr_en,
   output logic [AW-1:0] mem_wr_addr,
   output logic [31:0]   mem_wr_data,
   output logic          u_ld,
   output logic [2:0]    u_nbytes,
   output logic          u_eop,
   input  logic          u_busy,
   output logic          active,
   output logic          irq_set,
   output logic [AW-1:0] cur_ptr,
   output logic [AW-1:0] nxt_ptr
);
   localparam logic [AW-1:0] OFS_CTL = AW'(4);
   localparam logic [AW-1:0] OFS_NXT = AW'(8);
   localparam logic [AW-1:0] WORD_B  = AW'(4);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(4);

   wk_state_t      st_q;
   logic           pend_q;
   logic [AW-1:0]  cur_q, nxt_q, buf_q;
   logic [31:0]    ctl_q;
   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] left_after;
   logic           rd_state;
   logic           got;

   assign rd_state = (st_q == WK_GET_BUF) || (st_q == WK_GET_CTL) ||
                     (st_q == WK_GET_NXT) || (st_q == WK_GET_DATA);
   assign got      = rd_state && pend_q && mem_rd_valid;

   assign mem_rd_req = rd_state && !pend_q && !abort;
   always_comb begin
      unique case (st_q)
         WK_GET_CTL:  mem_rd_addr = cur_q + OFS_CTL;
         WK_GET_NXT:  mem_rd_addr = cur_q + OFS_NXT;
         WK_GET_DATA: mem_rd_addr = buf_q;
         default:     mem_rd_addr = cur_q;
      endcase
   end

   assign u_nbytes   = (left_q >= FULL) ? 3'd4 : left_q[2:0];
   assign left_after = left_q - CNT_W'(u_nbytes);
   assign u_ld       = got && (st_q == WK_GET_DATA) && !abort;
   assign u_eop      = ctl_q[CB_PKT_END] && (left_after == '0);

   assign mem_wr_en   = (st_q == WK_DONE) && !abort;
   assign mem_wr_addr = cur_q + OFS_CTL;
   assign mem_wr_data = ctl_q | (32'd1 << CB_DONE);
   assign irq_set     = mem_wr_en && ctl_q[CB_IRQ];

   assign active  = (st_q != WK_IDLE);
   assign cur_ptr = cur_q;
   assign nxt_ptr = nxt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= WK_IDLE;
         pend_q <= 1'b0;
         cur_q  <= '0;
         nxt_q  <= '0;
         buf_q  <= '0;
         ctl_q  <= '0;
         left_q <= '0;
      end else if (abort) begin
         st_q   <= WK_IDLE;
         pend_q <= 1'b0;
      end else begin
         if (mem_rd_req) pend_q <= 1'b1;
         if (got)        pend_q <= 1'b0;
         unique case (st_q)
            WK_IDLE: begin
               if (nxt_wr) nxt_q <= nxt_wdata;
               if (start) begin
                  cur_q <= nxt_q;
                  st_q  <= WK_GET_BUF;
               end
            end
            WK_GET_BUF: if (got) begin
               buf_q <= mem_rd_data[AW-1:0] & ~AW'(3);
               st_q  <= WK_GET_CTL;
            end
            WK_GET_CTL: if (got) begin
               ctl_q  <= mem_rd_data;
               left_q <= mem_rd_data[CNT_W-1:0];
               st_q   <= mem_rd_data[CB_HW_OWN] ? WK_GET_NXT : WK_IDLE;
            end
            WK_GET_NXT: if (got) begin
               nxt_q <= mem_rd_data[AW-1:0];
               st_q  <= (left_q == '0) ? WK_DONE : WK_GET_DATA;
            end
            WK_GET_DATA: if (got) begin
               left_q <= left_after;
               buf_q  <= buf_q + WORD_B;
               st_q   <= WK_EMIT;
            end
            WK_EMIT: if (!u_busy)
               st_q <= (left_q == '0) ? WK_DONE : WK_GET_DATA;
            WK_DONE: begin
               if (ctl_q[CB_RING_END]) begin
                  st_q <= WK_IDLE;
               end else begin
                  cur_q <= nxt_q;
                  st_q  <= WK_GET_BUF;
               end
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txdesc_dma.sv
`timescale 1ns/1ps
module txdesc_dma #(
   parameter int AW        = 32,
   parameter int CNT_W     = 13,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          irq,
   output logic          mem_rd_req,
   output logic [AW-1:0] mem_rd_addr,
   input  logic          mem_rd_valid,
   input  logic [31:0]   mem_rd_data,
   output logic          mem_wr_en,
   output logic [AW-1:0] mem_wr_addr,
   output logic [31:0]   mem_wr_data,
   output logic          fifo_valid,
   output logic [7:0]    fifo_data,
   output logic          fifo_last,
   input  logic          fifo_ready,
   input  logic          mac_evt,
   input  logic [3:0]    mac_flags
);
   generate
      if (AW < 4 || AW > 32) begin : g_bad_aw
         $error("txdesc_dma: AW must lie in 4..32");
      end
      if (CNT_W < 3 || CNT_W > 16) begin : g_bad_cnt
         $error("txdesc_dma: CNT_W must lie in 3..16");
      end
   endgenerate

   logic          eng_active;
   logic          eng_start, eng_abort, eng_nxt_wr, eng_irq_set;
   logic [AW-1:0] eng_cur, eng_nxt;
   logic          u_ld, u_eop, u_busy;
   logic [2:0]    u_nbytes;

   txdesc_regs #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cur_ptr(eng_cur), .nxt_ptr(eng_nxt), .active(eng_active),
      .irq_set(eng_irq_set), .mac_evt(mac_evt), .mac_flags(mac_flags),
      .start(eng_start), .nxt_wr(eng_nxt_wr), .abort(eng_abort), .irq(irq)
   );

   txdesc_walker #(.AW(AW), .CNT_W(CNT_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .start(eng_start), .abort(eng_abort),
      .nxt_wr(eng_nxt_wr), .nxt_wdata(reg_wdata[AW-1:0]),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .u_ld(u_ld), .u_nbytes(u_nbytes), .u_eop(u_eop), .u_busy(u_busy),
      .active(eng_active), .irq_set(eng_irq_set),
      .cur_ptr(eng_cur), .nxt_ptr(eng_nxt)
   );

   txdesc_unpack #(.MSB_FIRST(MSB_FIRST)) u_unpack (
      .clk(clk), .rst_n(rst_n), .clr(eng_abort),
      .ld(u_ld), .ld_word(mem_rd_data), .ld_nbytes(u_nbytes), .ld_eop(u_eop),
      .busy(u_busy),
      .out_valid(fifo_valid), .out_data(fifo_data), .out_last(fifo_last),
      .out_ready(fifo_ready)
   );
endmodule

// File: rtl/txdesc_dma_chk.sv
`timescale 1ns/1ps
module txdesc_dma_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_valid,
   input logic       fifo_ready,
   input logic [7:0] fifo_data,
   input logic       mem_rd_req,
   input logic       mem_wr_en,
   input logic       irq,
   input logic       active,
   input logic       reg_wr,
   input logic [1:0] reg_addr,
   input logic [31:0] reg_wdata,
   input logic       mac_evt,
   input logic [3:0] mac_flags
);
   logic fatal;
   logic ack;
   assign fatal = mac_evt && (mac_flags[2] || mac_flags[0]);
   assign ack   = reg_wr && (reg_addr == 2'd3) && reg_wdata[0];

   // R1
   one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);
   // R2
   hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_valid && !fifo_ready && !fatal) |=> (fifo_valid && $stable(fifo_data)));
   // R3
   wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> !fifo_valid);
   // R3
   wb_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> !mem_wr_en);
   // R4
   idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !mem_rd_req);
   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);
   // R9
   fatal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> (!active && !fifo_valid));
endmodule

bind txdesc_dma txdesc_dma_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
   .mem_rd_req(mem_rd_req), .mem_wr_en(mem_wr_en), .irq(irq),
   .active(eng_active),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .mac_evt(mac_evt), .mac_flags(mac_flags)
);

// File: tb/txdesc_dma_tb.sv
`timescale 1ns/1ps
module txdesc_dma_tb;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        mem_rd_req, mem_rd_valid;
   logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
   logic        mem_wr_en;
   logic        fifo_valid, fifo_last, fifo_ready;
   logic [7:0]  fifo_data;
   logic        mac_evt = 1'b0;
   logic [3:0]  mac_flags = '0;

   int nvec = 0, nfail = 0, popped = 0;
   logic [8:0] exp_q [$];
   logic [31:0] mem [0:127];
   logic        poke_en = 1'b0;
   logic [31:0] poke_addr = '0, poke_data = '0;
   logic [3:0]  rdy_cnt = '0;

   always #(CLK_NS/2) clk = ~clk;

   txdesc_dma u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
      .fifo_ready(fifo_ready), .mac_evt(mac_evt), .mac_flags(mac_flags)
   );

   function automatic logic [7:0] pat(int a);
      return 8'(a) ^ 8'h5A;
   endfunction

   // memory model: one-cycle read latency, write-back and bench pokes
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rd_valid <= 1'b0;
         for (int i = 0; i < 128; i++)
            mem[i] <= {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
      end else begin
         mem_rd_valid <= mem_rd_req;
         mem_rd_data  <= mem[mem_rd_addr[8:2]];
         if (mem_wr_en) mem[mem_wr_addr[8:2]] <= mem_wr_data;
         if (poke_en)   mem[poke_addr[8:2]] <= poke_data;
      end
   end

   always @(posedge clk) rdy_cnt <= rdy_cnt + 4'd1;
   assign fifo_ready = (rdy_cnt[1:0] != 2'b11);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && fifo_valid && fifo_ready) begin
         popped++;
         nvec++;
         if (exp_q.size() == 0) begin
            nfail++;
            $display("FAIL R2 actual=%h expected=<none>", {fifo_last, fifo_data});
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            if ({fifo_last, fifo_data} !== e) begin
               nfail++;
               $display("FAIL R2 actual=%h expected=%h", {fifo_last, fifo_data}, e);
            end
         end
      end
   end

   task automatic push_bytes(int base, int n, bit eop);
      for (int i = 0; i < n; i++)
         exp_q.push_back({eop && (i == n-1), pat(base + i)});
   endtask

   task automatic poke(int a, logic [31:0] d);
      @(negedge clk); poke_en = 1'b1; poke_addr = 32'(a); poke_data = d;
      @(negedge clk); poke_en = 1'b0;
   endtask

   task automatic host_wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic peek(logic [1:0] a, output logic [31:0] v);
      reg_addr = a; #1; v = reg_rdata;
   endtask

   task automatic host_rd(logic [1:0] a, output logic [31:0] v);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1; v = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic mac_event(logic [3:0] f);
      @(negedge clk); mac_evt = 1'b1; mac_flags = f;
      @(negedge clk); mac_evt = 1'b0; mac_flags = '0;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         peek(2'd2, v);
         if (!v[9]) break;
      end
   endtask

   task automatic start_at(int p);
      host_wr(2'd1, 32'(p));
      host_wr(2'd2, 32'h200);
   endtask

   initial begin
      #(CLK_NS * 150000);
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      peek(2'd2, v); chk("R12 status", v, 32'h0);
      peek(2'd0, v); chk("R12 cur", v, 32'h0);
      peek(2'd1, v); chk("R12 next", v, 32'h0);
      chk("R12 irq", {31'b0, irq}, 32'h0);
      chk("R12 fifo_valid", {31'b0, fifo_valid}, 32'h0);

      // R1 R2 R11 R3 chain of three descriptors
      poke(32'h00, 32'h100); poke(32'h04, 32'h4100_0005); poke(32'h08, 32'h10);
      poke(32'h10, 32'h180); poke(32'h14, 32'h0100_0000); poke(32'h18, 32'h20);
      poke(32'h20, 32'h140); poke(32'h24, 32'hE100_0007); poke(32'h28, 32'h1F0);
      push_bytes(32'h100, 5, 1'b1);
      push_bytes(32'h140, 7, 1'b1);
      start_at(32'h00);
      wait_idle();
      repeat (4) @(negedge clk);
      chk("R3 done d0", mem[1], 32'h4100_8005);
      chk("R11 done zero-count", mem[5], 32'h0100_8000);
      chk("R3 done d2", mem[9], 32'hE100_8007);
      chk("R2 all bytes sent", 32'(exp_q.size()), 32'h0);
      peek(2'd2, v); chk("R4 active clear", v & 32'h200, 32'h0);
      peek(2'd0, v); chk("R13 cur", v, 32'h20);
      peek(2'd1, v); chk("R13 next", v, 32'h1F0);
      chk("R7 irq set", {31'b0, irq}, 32'h1);
      host_wr(2'd3, 32'h1);
      @(negedge clk);
      chk("R7 irq cleared", {31'b0, irq}, 32'h0);

      // R5 unowned descriptor
      poke(32'h30, 32'h180); poke(32'h34, 32'h8000_0004); poke(32'h38, 32'h0);
      seen = popped;
      start_at(32'h30);
      wait_idle();
      repeat (4) @(negedge clk);
      chk("R5 no bytes", 32'(popped - seen), 32'h0);
      chk("R5 ctl untouched", mem[13], 32'h8000_0004);
      chk("R7 no irq without flag", {31'b0, irq}, 32'h0);

      // R6 next pointer write while active is ignored
      poke(32'h40, 32'h180); poke(32'h44, 32'hC100_0028); poke(32'h48, 32'h1E0);
      push_bytes(32'h180, 40, 1'b1);
      start_at(32'h40);
      repeat (15) @(negedge clk);
      host_wr(2'd1, 32'h1C0);
      wait_idle();
      repeat (2) @(negedge clk);
      peek(2'd1, v); chk("R6 next write ignored", v, 32'h1E0);
      peek(2'd0, v); chk("R13 cur single", v, 32'h40);
      chk("R2 long buffer", 32'(exp_q.size()), 32'h0);
      chk("R7 no irq without flag", {31'b0, irq}, 32'h0);

      // R8 R10 status stickiness and read flag
      mac_event(4'b1010);
      peek(2'd2, v); chk("R8 ok+coll", v, 32'h00A);
      host_rd(2'd2, v); chk("R10 read value", v, 32'h00A);
      peek(2'd2, v); chk("R10 read flag set", v, 32'h08A);
      mac_event(4'b0010);
      peek(2'd2, v); chk("R10 flag cleared by event", v, 32'h00A);

      // R9 fatal underflow mid-stream
      poke(32'h50, 32'h100); poke(32'h54, 32'hE100_003C); poke(32'h58, 32'h0);
      push_bytes(32'h100, 60, 1'b1);
      start_at(32'h50);
      peek(2'd2, v); chk("R8 cleared by start", v, 32'h200);
      repeat (20) @(negedge clk);
      mac_event(4'b0001);
      peek(2'd2, v); chk("R9 halted with underflow", v, 32'h001);
      chk("R9 stream dropped", {31'b0, fifo_valid}, 32'h0);
      exp_q.delete();
      seen = popped;
      repeat (10) @(negedge clk);
      chk("R9 no further bytes", 32'(popped - seen), 32'h0);
      chk("R9 no done written", mem[21], 32'hE100_003C);
      chk("R9 no irq", {31'b0, irq}, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule